// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh and Power Control

This block turns single-beat host read and write requests for two SDRAM chip-select areas into a legal sequence of SDRAM commands. It also keeps the devices refreshed and controls their power state. A four-bit mode word, written through a small configuration port, selects the behaviour. One bit enables refresh. A second bit chooses between timed auto-refresh and immediate self-refresh. A third bit drops CKE into power-down once each access completes. A fourth bit lets area 3 keep its row open between accesses instead of closing it with auto-precharge.

A free-running refresh counter, compared against a programmable limit, paces auto-refresh. If a row is open when a refresh or a self-refresh entry comes due, the block closes it first. CKE is raised at least one cycle before any command, so the device leaves power-down in time. After self-refresh ends, the block waits a fixed delay before it issues any command. The SDRAM array, its initialisation and the data path are outside this block.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset, sd_cke is 1, both chip selects are high, req_ready is 1, acc_done is 0, the mode word reads 0 and the refresh compare value reads all ones.
- R2: With cfg_sel=0 the port accesses the mode word: bit 0 enables refresh, bit 1 selects self-refresh, bit 2 selects power-down after access, bit 3 selects open-row access. Bits 15:4 always read 0 and writes to them have no effect. With cfg_sel=1 the port accesses the refresh compare value, zero-extended on read.
- R3: In auto-precharge mode an access issues ACTIVE and then, T_RCD cycles later, READ or WRITE with sd_addr[10]=1. acc_done pulses for one cycle, T_RP cycles after the READ or WRITE. In open-row mode acc_done pulses 1 cycle after it.
- R4: In open-row mode, an area 3 access issues READ or WRITE with sd_addr[10]=0 and the row stays open. A later access to the same bank and row issues READ or WRITE without ACTIVE. An access to another row issues PRECHARGE with sd_addr[10]=1, then ACTIVE T_RP cycles later, then READ or WRITE T_RCD cycles after that.
- R5: Area 2 accesses always use auto-precharge. While area2_sdram is 1, area 3 accesses also use auto-precharge, whatever the mode word says. An open area 3 row that is hit in this state is read with sd_addr[10]=1 and is closed.
- R6: Commands use {sd_ras_n,sd_cas_n,sd_we_n}: ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, REFRESH 001. sd_cs_n bit 0 selects area 2, bit 1 selects area 3, and refresh drives both low. No other command is issued.
- R7: sd_cke is 1 in every command cycle and in the cycle before it, except for self-refresh entry. With the power-down bit set, sd_cke goes low in the acc_done cycle and stays low until new work arrives. With the bit clear, sd_cke stays 1 after an access.
- R8: With refresh enabled and timed mode selected, REFRESH (sd_cke=1) repeats every compare+1 cycles while the block is idle. An open row is precharged T_RP cycles before the refresh. No command follows a refresh for T_RC cycles.
- R9: With refresh enabled and self-refresh selected, the block precharges any open row and then issues REFRESH with sd_cke=0 in the same cycle. sd_cke stays low until the refresh-enable bit is cleared. After that, sd_cke rises and no command follows for at least T_XSR cycles.
- R10: req_ready is 0 while self-refresh is requested or in progress, and while a timed refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: mode word, 1: refresh compare value |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for cfg_sel |
| area2_sdram | input | 1 | Area 2 is also SDRAM (forces auto-precharge) |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_area3 | input | 1 | 1: area 3, 0: area 2 |
| req_write | input | 1 | 1: write, 0: read |
| req_bank | input | BA_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| acc_done | output | 1 | One-cycle access completion pulse |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Row, column or precharge-all address |

## Verification
The hardest situations to reach are the ones where an open area 3 row meets another event. These are a refresh deadline, a self-refresh request, and the area2_sdram override applied after the row was opened. The stimulus first performs an open-row access to leave a row open. Only then does it enable timed refresh or self-refresh, or raise area2_sdram, so the precharge-first and forced-close paths run. Self-refresh exit is reached by holding a request pending while clearing the enable bit, so the exit delay to the first command is measured at the ports.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int BA_W  = 2,
  parameter int CNT_W = 10,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 6,
  parameter int T_XSR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             area2_sdram,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_area3,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             acc_done,
  output logic             sd_cke,
  output logic [1:0]       sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr
);
  localparam int AP_BIT = 10;
  localparam int WAIT_W = $clog2(T_RCD + T_RP + T_RC + T_XSR + 1);
  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [1:0] CS_A2 = 2'b10;
  localparam logic [1:0] CS_A3 = 2'b01;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ACT, S_RW, S_REF, S_SRE, S_SREF, S_WAIT, S_FIN
  } state_t;

  state_t st, ret;
  logic [WAIT_W-1:0] wcnt;
  logic [3:0] mode;
  logic [CNT_W-1:0] rcmp, rcnt;
  logic ref_pend;
  logic open_v;
  logic [BA_W-1:0] open_ba;
  logic [ROW_W-1:0] open_row;
  logic l_a3, l_wr, l_ap;
  logic [BA_W-1:0] l_ba;
  logic [ROW_W-1:0] l_row;
  logic [COL_W-1:0] l_col;
  logic [2:0] cmd_r;
  logic [ROW_W-1:0] rw_addr;
  logic ren, rmode, pd, bact, sref_req, tmr_hit, hit, cfg_unused;

  assign ren      = mode[0];
  assign rmode    = mode[1];
  assign pd       = mode[2];
  assign bact     = mode[3];
  assign sref_req = ren & rmode;
  assign tmr_hit  = ren & ~rmode & (rcnt == rcmp);
  assign hit      = open_v & req_area3 & (open_ba == req_bank) & (open_row == req_row);
  assign req_ready = (st == S_IDLE) & ~sref_req & ~ref_pend;
  assign cfg_rdata = cfg_sel ? {{(16-CNT_W){1'b0}}, rcmp} : {12'h000, mode};
  assign cfg_unused = ^cfg_wdata[15:CNT_W];
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_r;

  always_comb begin
    rw_addr = '0;
    rw_addr[COL_W-1:0] = l_col;
    rw_addr[AP_BIT] = l_ap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      rcmp <= '1;
    end else if (cfg_we) begin
      if (cfg_sel) rcmp <= cfg_wdata[CNT_W-1:0];
      else         mode <= cfg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (!ren || rmode)  rcnt <= '0;
      else if (tmr_hit)   rcnt <= '0;
      else                rcnt <= rcnt + 1'b1;
      if (tmr_hit)                          ref_pend <= 1'b1;
      else if (st == S_REF || st == S_SRE)  ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ret <= S_IDLE;
      wcnt <= '0;
      open_v <= 1'b0;
      open_ba <= '0;
      open_row <= '0;
      l_a3 <= 1'b0;
      l_wr <= 1'b0;
      l_ap <= 1'b1;
      l_ba <= '0;
      l_row <= '0;
      l_col <= '0;
      sd_cke <= 1'b1;
      sd_cs_n <= 2'b11;
      cmd_r <= C_NOP;
      sd_ba <= '0;
      sd_addr <= '0;
      acc_done <= 1'b0;
    end else begin
      sd_cs_n <= 2'b11;
      cmd_r <= C_NOP;
      sd_ba <= '0;
      sd_addr <= '0;
      acc_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sref_req) begin
            sd_cke <= 1'b1;
            ret <= S_SRE;
            st <= open_v ? S_PRE : S_SRE;
          end else if (ref_pend) begin
            sd_cke <= 1'b1;
            ret <= S_REF;
            st <= open_v ? S_PRE : S_REF;
          end else if (req_valid) begin
            sd_cke <= 1'b1;
            l_a3 <= req_area3;
            l_wr <= req_write;
            l_ba <= req_bank;
            l_row <= req_row;
            l_col <= req_col;
            l_ap <= ~(bact & ~area2_sdram & req_area3);
            ret <= S_ACT;
            if (hit)                        st <= S_RW;
            else if (open_v && req_area3)   st <= S_PRE;
            else                            st <= S_ACT;
          end
        end
        S_PRE: begin
          sd_cs_n <= CS_A3;
          cmd_r <= C_PRE;
          sd_addr <= ROW_W'(1) << AP_BIT;
          open_v <= 1'b0;
          wcnt <= WAIT_W'(T_RP - 2);
          st <= S_WAIT;
        end
        S_ACT: begin
          sd_cs_n <= l_a3 ? CS_A3 : CS_A2;
          cmd_r <= C_ACT;
          sd_ba <= l_ba;
          sd_addr <= l_row;
          if (l_a3 && !l_ap) begin
            open_v <= 1'b1;
            open_ba <= l_ba;
            open_row <= l_row;
          end
          wcnt <= WAIT_W'(T_RCD - 2);
          ret <= S_RW;
          st <= S_WAIT;
        end
        S_RW: begin
          sd_cs_n <= l_a3 ? CS_A3 : CS_A2;
          cmd_r <= l_wr ? C_WR : C_RD;
          sd_ba <= l_ba;
          sd_addr <= rw_addr;
          if (l_ap) begin
            if (l_a3) open_v <= 1'b0;
            wcnt <= WAIT_W'(T_RP - 2);
            ret <= S_FIN;
            st <= S_WAIT;
          end else begin
            st <= S_FIN;
          end
        end
        S_REF: begin
          sd_cs_n <= 2'b00;
          cmd_r <= C_REF;
          wcnt <= WAIT_W'(T_RC - 2);
          ret <= S_IDLE;
          st <= S_WAIT;
        end
        S_SRE: begin
          sd_cs_n <= 2'b00;
          cmd_r <= C_REF;
          sd_cke <= 1'b0;
          st <= S_SREF;
        end
        S_SREF: begin
          if (!sref_req) begin
            sd_cke <= 1'b1;
            wcnt <= WAIT_W'(T_XSR - 2);
            ret <= S_IDLE;
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (wcnt == '0) st <= ret;
          else            wcnt <= wcnt - 1'b1;
        end
        S_FIN: begin
          acc_done <= 1'b1;
          sd_cke <= ~pd;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cke,
  input logic [1:0]       sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             acc_done
);
  logic any_cmd, is_ref, is_act, is_pre, is_rw;
  assign any_cmd = sd_cs_n != 2'b11;
  assign is_ref  = any_cmd && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001;
  assign is_act  = any_cmd && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b011;
  assign is_pre  = any_cmd && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b010;
  assign is_rw   = any_cmd && sd_ras_n && !sd_cas_n;

  // R7
  cke_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cmd && !(is_ref && !sd_cke)) |-> (sd_cke && $past(sd_cke)));
  // R9
  sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && !sd_cke) |=> !any_cmd);
  // R5
  area2_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && sd_cs_n == 2'b10) |-> sd_addr[10]);
  // R3
  act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> !any_cmd);
  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> sd_addr[10]);
  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !any_cmd);
  // R8
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && sd_cke) |=> !any_cmd);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);
  // R6
  cs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cmd && !is_ref) |-> $onehot0(~sd_cs_n));
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .acc_done(acc_done)
);

// File: tb/test_sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module test_sdram_cmd_ctrl;
  localparam int ROW_W = 13, COL_W = 9, BA_W = 2, CNT_W = 10;
  localparam int T_RCD = 3, T_RP = 3, T_RC = 6, T_XSR = 8;
  localparam int PERIOD = 40;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic area2_sdram = 0, req_valid = 0, req_ready, req_area3 = 0, req_write = 0;
  logic [BA_W-1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic acc_done, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_cs_n;
  logic [BA_W-1:0] sd_ba;
  logic [ROW_W-1:0] sd_addr;

  sdram_cmd_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_XSR(T_XSR)) i_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .area2_sdram(area2_sdram), .req_valid(req_valid),
    .req_ready(req_ready), .req_area3(req_area3), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .acc_done(acc_done),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0] cmd; logic [1:0] cs; logic [BA_W-1:0] ba; logic [ROW_W-1:0] addr;
    int gap; bit sref; string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;
  int cyc = 0, n_chk = 0, n_bad = 0;
  int last_cmd_cyc = 0, last_rw_cyc = 0, cke_rise_cyc = 0;
  bit watch_exit = 0;
  logic prev_cke = 1;
  logic [2:0] mc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [2:0] c, logic [1:0] cs, logic [BA_W-1:0] ba,
                      logic [ROW_W-1:0] addr, int gap, bit sref, string tag);
    exp_t x;
    x.cmd = c; x.cs = cs; x.ba = ba; x.addr = addr; x.gap = gap; x.sref = sref; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: pops the scoreboard on every command seen on the pins
  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_cs_n != 2'b11) begin
        mc = {sd_ras_n, sd_cas_n, sd_we_n};
        if (q.size() == 0) chk(0, "R6", "unexpected command", mc, 0);
        else begin
          e = q.pop_front();
          chk(mc == e.cmd && sd_cs_n == e.cs && sd_ba == e.ba && sd_addr == e.addr,
              e.tag, "command {cmd,cs,ba,addr}", {mc, sd_cs_n, sd_ba, sd_addr},
              {e.cmd, e.cs, e.ba, e.addr});
          chk(sd_cke == !e.sref, e.tag, "cke in command cycle", sd_cke, !e.sref);
          if (e.gap != 0) chk(cyc - last_cmd_cyc == e.gap, e.tag, "command spacing",
                              cyc - last_cmd_cyc, e.gap);
          if (!e.sref) chk(prev_cke, "R7", "cke high before command", prev_cke, 1);
        end
        if (watch_exit) begin
          chk(cyc - cke_rise_cyc >= T_XSR, "R9", "exit delay", cyc - cke_rise_cyc, T_XSR);
          watch_exit = 0;
        end
        last_cmd_cyc = cyc;
        if (sd_ras_n && !sd_cas_n) last_rw_cyc = cyc;
      end
      if (sd_cke && !prev_cke) cke_rise_cyc = cyc;
      prev_cke = sd_cke;
    end
  end

  task automatic cfg_wr(bit sel, logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(bit sel, logic [15:0] exp, string tag);
    @(negedge clk); cfg_sel = sel; #1;
    chk(cfg_rdata == exp, tag, "config read", cfg_rdata, exp);
  endtask

  // kind: 0 closed row, 1 open-row hit, 2 open-row miss
  task automatic run(bit a3, bit wr, logic [BA_W-1:0] ba, logic [ROW_W-1:0] row,
                     logic [COL_W-1:0] col, int kind, bit ap, bit exp_cke, string tag);
    logic [1:0] cs = a3 ? 2'b01 : 2'b10;
    logic [ROW_W-1:0] ca = '0;
    int t = 0;
    ca[COL_W-1:0] = col; ca[10] = ap;
    if (kind == 2) push(C_PRE, 2'b01, '0, ROW_W'(1) << 10, 0, 0, tag);
    if (kind != 1) push(C_ACT, cs, ba, row, (kind == 2) ? T_RP : 0, 0, tag);
    push(wr ? C_WR : C_RD, cs, ba, ca, (kind == 1) ? 0 : T_RCD, 0, tag);
    @(negedge clk);
    req_area3 = a3; req_write = wr; req_bank = ba; req_row = row; req_col = col; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!acc_done && t < 200) begin @(negedge clk); t++; end
    chk(acc_done, tag, "acc_done seen", acc_done, 1);
    chk(cyc - last_rw_cyc == (ap ? T_RP : 1), tag, "done after command",
        cyc - last_rw_cyc, ap ? T_RP : 1);
    chk(sd_cke == exp_cke, "R7", "cke at done", sd_cke, exp_cke);
  endtask

  task automatic drain(string tag);
    int t = 0;
    while (q.size() != 0 && t < 400) begin @(negedge clk); t++; end
    chk(q.size() == 0, tag, "expected commands left", q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sd_cke == 1, "R1", "cke", sd_cke, 1);
    chk(sd_cs_n == 2'b11, "R1", "cs_n", sd_cs_n, 3);
    chk(req_ready == 1, "R1", "ready", req_ready, 1);
    chk(acc_done == 0, "R1", "done", acc_done, 0);
    cfg_rd(0, 16'h0000, "R1");
    cfg_rd(1, 16'h03FF, "R1");
    // R2 reserved bits and compare value
    cfg_wr(0, 16'hFFF0);
    cfg_rd(0, 16'h0000, "R2");
    cfg_wr(0, 16'hA00C);
    cfg_rd(0, 16'h000C, "R2");
    cfg_wr(0, 16'h0000);
    cfg_wr(1, 16'(PERIOD - 1));
    cfg_rd(1, 16'(PERIOD - 1), "R2");
    // R3 auto-precharge access, both areas
    run(0, 0, 2'd2, 13'h123, 9'h045, 0, 1, 1, "R3");
    run(1, 1, 2'd1, 13'h0A5, 9'h1F0, 0, 1, 1, "R3");
    // R4 open-row mode: open, hit, miss
    cfg_wr(0, 16'h0008);
    run(1, 0, 2'd1, 13'd5, 9'd3, 0, 0, 1, "R4");
    run(1, 1, 2'd1, 13'd5, 9'd4, 1, 0, 1, "R4");
    run(1, 0, 2'd1, 13'd7, 9'd6, 2, 0, 1, "R4");
    // R5 area 2 ignores open-row mode; area2_sdram forces close of open row
    run(0, 0, 2'd0, 13'd9, 9'd1, 0, 1, 1, "R5");
    area2_sdram = 1;
    run(1, 0, 2'd1, 13'd7, 9'd2, 1, 1, 1, "R5");
    run(1, 1, 2'd1, 13'd7, 9'd2, 0, 1, 1, "R5");
    area2_sdram = 0;
    // R7 power-down after access
    cfg_wr(0, 16'h0004);
    run(0, 1, 2'd3, 13'd11, 9'd8, 0, 1, 0, "R7");
    repeat (5) @(negedge clk);
    chk(sd_cke == 0, "R7", "cke stays low when idle", sd_cke, 0);
    run(0, 0, 2'd3, 13'd11, 9'd9, 0, 1, 0, "R7");
    cfg_wr(0, 16'h0000);
    run(0, 0, 2'd0, 13'd12, 9'd1, 0, 1, 1, "R7");
    // R8 timed refresh with an open row
    cfg_wr(0, 16'h0008);
    run(1, 0, 2'd3, 13'd2, 9'd1, 0, 0, 1, "R8");
    push(C_PRE, 2'b01, '0, ROW_W'(1) << 10, 0, 0, "R8");
    push(C_REF, 2'b00, '0, '0, T_RP, 0, "R8");
    push(C_REF, 2'b00, '0, '0, 0, 0, "R8");
    push(C_REF, 2'b00, '0, '0, PERIOD, 0, "R8");
    cfg_wr(0, 16'h0009);
    drain("R8");
    cfg_wr(0, 16'h0000);
    repeat (60) @(negedge clk);
    // R9 self-refresh with an open row, then exit with a request waiting
    cfg_wr(0, 16'h0008);
    run(1, 0, 2'd0, 13'd4, 9'd1, 0, 0, 1, "R9");
    push(C_PRE, 2'b01, '0, ROW_W'(1) << 10, 0, 0, "R9");
    push(C_REF, 2'b00, '0, '0, T_RP, 1, "R9");
    cfg_wr(0, 16'h000B);
    drain("R9");
    repeat (10) @(negedge clk);
    chk(sd_cke == 0, "R9", "cke low in self-refresh", sd_cke, 0);
    chk(req_ready == 0, "R10", "ready in self-refresh", req_ready, 0);
    watch_exit = 1;
    cfg_wr(0, 16'h0000);
    run(0, 0, 2'd1, 13'd3, 9'd2, 0, 1, 1, "R9");
    chk(watch_exit == 0, "R9", "command after exit observed", watch_exit, 0);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R6", "scoreboard empty", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule